// File: doc/BRIEF.md
# Pointer Tag Signing and Checking Unit

This block protects 64-bit pointers with a keyed tag kept in the address bits above the virtual address range. A sign request combines the pointer, a 64-bit context value and a 128-bit key in an iterative add-rotate-xor mix. It truncates the 64-bit digest and writes the truncated value into the upper bits of the pointer. An authenticate request recomputes the tag for the address part and compares it with the tag in the pointer. If they match, the unit returns the pointer in canonical form. If they do not, the unit returns a poisoned pointer that any later address translation rejects. A strip request returns the canonical form at once and checks nothing.

Requests and responses use valid/ready handshakes. Sign and authenticate requests run one mix round per cycle. While the rounds run, `busy` is high. The unit takes no new request until the response has been accepted.

Top module: `ptr_tag_unit`

## Requirements
- R1: A sign request (`req_op` = 2'b00) on a canonical pointer returns address bits [47:0] unchanged and the tag in bits [63:48], with `error_flag` low. A pointer is canonical when bits [63:47] are all equal.
- R2: The digest is computed over the canonical form P of the address bits, the context C and the key halves Klo = key[63:0] and Khi = key[127:64]. Set a = P^Klo and b = C^Khi. Each of 4 rounds r = 0..3 then does the following, in order: t = a+b (mod 2^64); b = rotl(b,17)^t; a = rotl(t,32)^(Klo if r is even, else Khi)^r. The digest is a^b, and the raw tag is digest[15:0].
- R3: If the top two bits of the raw tag are 2'b10, they are replaced by 2'b11. A response with `error_flag` low therefore never has bits [63:62] = 2'b10.
- R4: An authenticate request (`req_op` = 2'b01) whose bits [63:48] equal the tag for its address bits, its context and its key returns the sign-extension of bit 47, with `error_flag` low.
- R5: An authenticate request whose tag does not match returns 2'b10 in bits [63:62] and the canonical form in bits [61:0], with `error_flag` high.
- R6: A sign request on a non-canonical pointer returns {2'b10, tag[13:0], address[47:0]} with `error_flag` high. Authenticating that result always fails.
- R7: A strip request (`req_op` = 2'b10, and 2'b11 behaves the same) returns the sign-extension of bit 47 with `error_flag` low. Its response is valid one cycle after acceptance.
- R8: A sign or authenticate response is valid 5 cycles after acceptance (one load cycle plus one per round). `busy` is high during the rounds.
- R9: `req_ready` is low from acceptance until the response handshake. Requests presented meanwhile are ignored.
- R10: While `rsp_valid` is high and `rsp_ready` is low, `rsp_ptr` and `error_flag` hold their values.
- R11: After reset, `req_ready` is high and `rsp_valid` and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request |
| req_op | input | 2 | 00 sign, 01 authenticate, 10/11 strip |
| req_ptr | input | 64 | Pointer operand |
| req_ctx | input | 64 | Context value |
| req_key | input | 128 | Key |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response accepted |
| rsp_ptr | output | 64 | Resulting pointer |
| error_flag | output | 1 | Result is poisoned |
| busy | output | 1 | Mix rounds in progress |

## Verification
The checker confirms on every cycle that the handshake behaves and that a held response stays stable. It also confirms that the ready and busy signals never overlap and that no round burst runs longer than the round count. It further confirms that the poison marker in bits [63:62] appears exactly when the error flag is raised. Only the bench scenarios can show that tags match the keyed digest. The same holds for sign-then-authenticate round trips, and for failures caused by a tampered tag, a wrong context or a poisoned sign result. The bench also shows that requests sent while the unit is busy leave the pending result untouched.

// File: rtl/pta_pkg.sv
package pta_pkg;

    localparam int PTR_W = 64;
    localparam int KEY_W = 128;

    typedef enum logic [1:0] {
        OP_SIGN  = 2'b00,
        OP_AUTH  = 2'b01,
        OP_STRIP = 2'b10,
        OP_RSVD  = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_RUN  = 2'b01,
        ST_RESP = 2'b10
    } state_e;

    typedef struct packed {
        logic [PTR_W-1:0] a;
        logic [PTR_W-1:0] b;
    } mix_t;

    function automatic mix_t mix_seed(logic [PTR_W-1:0] p, logic [PTR_W-1:0] c,
                                      logic [KEY_W-1:0] k);
        mix_t s;
        s.a = p ^ k[63:0];
        s.b = c ^ k[127:64];
        return s;
    endfunction

    function automatic mix_t mix_round(mix_t s, logic [PTR_W-1:0] k, logic [PTR_W-1:0] rc);
        mix_t n;
        logic [PTR_W-1:0] t;
        t   = s.a + s.b;
        n.b = {s.b[46:0], s.b[63:47]} ^ t;
        n.a = {t[31:0], t[63:32]} ^ k ^ rc;
        return n;
    endfunction

endpackage

// File: rtl/pta_mix_core.sv
module pta_mix_core
    import pta_pkg::*;
#(
    parameter int ROUNDS = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [PTR_W-1:0] ptr_in,
    input  logic [PTR_W-1:0] ctx_in,
    input  logic [KEY_W-1:0] key_in,
    output logic             running,
    output logic             last,
    output logic [PTR_W-1:0] digest
);
    localparam int CNT_W = (ROUNDS > 1) ? $clog2(ROUNDS) : 1;

    mix_t             st_q;
    logic [KEY_W-1:0] key_q;
    logic [CNT_W-1:0] cnt_q;
    logic [PTR_W-1:0] round_key;

    assign last      = running && (cnt_q == CNT_W'(ROUNDS - 1));
    assign round_key = cnt_q[0] ? key_q[127:64] : key_q[63:0];
    assign digest    = st_q.a ^ st_q.b;

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            cnt_q   <= '0;
            st_q    <= '0;
            key_q   <= '0;
        end else if (load) begin
            running <= 1'b1;
            cnt_q   <= '0;
            st_q    <= mix_seed(ptr_in, ctx_in, key_in);
            key_q   <= key_in;
        end else if (running) begin
            st_q  <= mix_round(st_q, round_key, PTR_W'(cnt_q));
            cnt_q <= cnt_q + 1'b1;
            if (last) running <= 1'b0;
        end
    end
endmodule

// File: rtl/pta_fmt.sv
module pta_fmt
    import pta_pkg::*;
#(
    parameter int VA_W = 48
) (
    input  op_e              op,
    input  logic [PTR_W-1:0] ptr,
    input  logic [PTR_W-1:0] digest,
    output logic [PTR_W-1:0] out_ptr,
    output logic             poison
);
    localparam int TAG_W = PTR_W - VA_W;

    logic [VA_W-1:0]  addr;
    logic [PTR_W-1:0] canon;
    logic [PTR_W-1:0] signed_ptr;
    logic [TAG_W-1:0] tag;
    logic             is_canon;
    logic             tag_match;

    assign addr     = ptr[VA_W-1:0];
    assign canon    = {{TAG_W{addr[VA_W-1]}}, addr};
    assign is_canon = (&ptr[PTR_W-1:VA_W-1]) | ~(|ptr[PTR_W-1:VA_W-1]);

    always_comb begin
        tag = digest[TAG_W-1:0];
        if (tag[TAG_W-1:TAG_W-2] == 2'b10) tag[TAG_W-1:TAG_W-2] = 2'b11;
    end

    assign signed_ptr = {tag, addr};
    assign tag_match  = (ptr[PTR_W-1:VA_W] == tag);

    always_comb begin
        case (op)
            OP_SIGN: begin
                poison  = !is_canon;
                out_ptr = is_canon ? signed_ptr : {2'b10, signed_ptr[PTR_W-3:0]};
            end
            OP_AUTH: begin
                poison  = !tag_match;
                out_ptr = tag_match ? canon : {2'b10, canon[PTR_W-3:0]};
            end
            default: begin
                poison  = 1'b0;
                out_ptr = canon;
            end
        endcase
    end
endmodule

// File: rtl/ptr_tag_unit.sv
module ptr_tag_unit
    import pta_pkg::*;
#(
    parameter int VA_W   = 48,
    parameter int ROUNDS = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         req_valid,
    output logic         req_ready,
    input  logic [1:0]   req_op,
    input  logic [63:0]  req_ptr,
    input  logic [63:0]  req_ctx,
    input  logic [127:0] req_key,
    output logic         rsp_valid,
    input  logic         rsp_ready,
    output logic [63:0]  rsp_ptr,
    output logic         error_flag,
    output logic         busy
);
    localparam int TAG_W = PTR_W - VA_W;

    state_e           state_q;
    op_e              op_q;
    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] req_canon;
    logic [PTR_W-1:0] digest;
    logic             accept;
    logic             needs_mix;
    logic             mix_last;
    logic             mix_running;
    logic             poison;

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign needs_mix = (op_e'(req_op) == OP_SIGN) || (op_e'(req_op) == OP_AUTH);
    assign req_canon = {{TAG_W{req_ptr[VA_W-1]}}, req_ptr[VA_W-1:0]};

    pta_mix_core #(.ROUNDS(ROUNDS)) u_mix (
        .clk     (clk),
        .rst     (rst),
        .load    (accept && needs_mix),
        .ptr_in  (req_canon),
        .ctx_in  (req_ctx),
        .key_in  (req_key),
        .running (mix_running),
        .last    (mix_last),
        .digest  (digest)
    );

    pta_fmt #(.VA_W(VA_W)) u_fmt (
        .op      (op_q),
        .ptr     (ptr_q),
        .digest  (digest),
        .out_ptr (rsp_ptr),
        .poison  (poison)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            op_q    <= OP_STRIP;
            ptr_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (accept) begin
                    op_q    <= op_e'(req_op);
                    ptr_q   <= req_ptr;
                    state_q <= needs_mix ? ST_RUN : ST_RESP;
                end
                ST_RUN:  if (mix_last) state_q <= ST_RESP;
                ST_RESP: if (rsp_ready) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign rsp_valid  = (state_q == ST_RESP);
    assign error_flag = rsp_valid && poison;
    assign busy       = mix_running;
endmodule

// File: rtl/pta_chk.sv
module pta_chk #(
    parameter int ROUNDS = 4
) (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_ready,
    input logic        rsp_valid,
    input logic        rsp_ready,
    input logic [63:0] rsp_ptr,
    input logic        error_flag,
    input logic        busy
);
    logic [31:0] busy_len;

    always_ff @(posedge clk) begin
        if (rst || !busy) busy_len <= '0;
        else              busy_len <= busy_len + 1'b1;
    end

    // R11
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (req_ready && !rsp_valid && !busy));

    // R9
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (!req_ready && !rsp_valid));

    // R9
    accept_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R10
    rsp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_ptr) && $stable(error_flag)));

    // R5
    poison_mark_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && error_flag) |-> (rsp_ptr[63:62] == 2'b10));

    // R3
    clean_top_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !error_flag) |-> (rsp_ptr[63:62] != 2'b10));

    // R8
    round_len_chk: assert property (@(posedge clk) disable iff (rst)
        busy_len <= 32'(ROUNDS));
endmodule

bind ptr_tag_unit pta_chk #(.ROUNDS(ROUNDS)) u_pta_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .rsp_ready  (rsp_ready),
    .rsp_ptr    (rsp_ptr),
    .error_flag (error_flag),
    .busy       (busy)
);

// File: tb/tb_ptr_tag_unit.sv
module tb_ptr_tag_unit;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [1:0]   req_op = 2'b10;
    logic [63:0]  req_ptr = '0;
    logic [63:0]  req_ctx = '0;
    logic [127:0] req_key = '0;
    logic         rsp_valid;
    logic         rsp_ready = 1'b0;
    logic [63:0]  rsp_ptr;
    logic         error_flag;
    logic         busy;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    ptr_tag_unit dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_ptr(req_ptr), .req_ctx(req_ctx), .req_key(req_key),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_ptr(rsp_ptr),
        .error_flag(error_flag), .busy(busy)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    function automatic logic [63:0] rl(logic [63:0] x, int s);
        return (x << s) | (x >> (64 - s));
    endfunction

    function automatic logic [63:0] canon_of(logic [63:0] p);
        return {{16{p[47]}}, p[47:0]};
    endfunction

    // R2 / R3 reference tag
    function automatic logic [15:0] ref_tag(logic [63:0] p, logic [63:0] c, logic [127:0] k);
        logic [63:0] a, b, t;
        logic [15:0] tg;
        a = canon_of(p) ^ k[63:0];
        b = c ^ k[127:64];
        for (int r = 0; r < 4; r++) begin
            t = a + b;
            b = rl(b, 17) ^ t;
            a = rl(t, 32) ^ ((r % 2 == 0) ? k[63:0] : k[127:64]) ^ 64'(r);
        end
        tg = 16'(a ^ b);
        if (tg[15:14] == 2'b10) tg[15:14] = 2'b11;
        return tg;
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run(input logic [1:0] op, input logic [63:0] p, input logic [63:0] c,
                       input logic [127:0] k, input bit hammer,
                       output logic [63:0] res, output logic err, output int lat,
                       output logic busy_seen);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_ptr = p; req_ctx = c; req_key = k;
        @(negedge clk);
        lat = 1;
        busy_seen = busy;
        if (hammer) begin
            req_op = 2'b10; req_ptr = ~p; req_ctx = ~c;
        end else begin
            req_valid = 1'b0;
        end
        while (!rsp_valid && lat < 50) begin
            @(negedge clk);
            lat++;
        end
        req_valid = 1'b0;
        res = rsp_ptr;
        err = error_flag;
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
    endtask

    function automatic logic [63:0] rnd_canon();
        logic [63:0] v;
        v = {$urandom, $urandom};
        return canon_of(v);
    endfunction

    initial begin
        logic [63:0] p, c, s, res, exp;
        logic [127:0] k;
        logic err, bs;
        int lat;
        void'($urandom(32'd1234));

        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 ready", 64'(req_ready), 64'd1);
        check("R11 rsp_valid", 64'(rsp_valid), 64'd0);
        check("R11 busy", 64'(busy), 64'd0);
        rst = 1'b0;

        for (int i = 0; i < 40; i++) begin
            p = rnd_canon();
            c = {$urandom, $urandom};
            k = {$urandom, $urandom, $urandom, $urandom};
            // R1 R2 R8 sign
            run(2'b00, p, c, k, 1'b0, s, err, lat, bs);
            exp = {ref_tag(p, c, k), p[47:0]};
            check("R1 sign", s, exp);
            check("R1 sign err", 64'(err), 64'd0);
            check("R8 latency", 64'(lat), 64'd5);
            check("R8 busy", 64'(bs), 64'd1);
            // R4 auth round trip
            run(2'b01, s, c, k, 1'b0, res, err, lat, bs);
            check("R4 auth ok", res, p);
            check("R4 auth err", 64'(err), 64'd0);
            // R5 tampered tag
            run(2'b01, s ^ (64'd1 << (48 + (i % 16))), c, k, 1'b0, res, err, lat, bs);
            check("R5 tamper", res, {2'b10, p[61:0]});
            check("R5 tamper err", 64'(err), 64'd1);
            // R5 wrong context
            run(2'b01, s, c ^ 64'd1, k, 1'b0, res, err, lat, bs);
            exp = (ref_tag(p, c ^ 64'd1, k) == s[63:48]) ? p : {2'b10, p[61:0]};
            check("R5 wrong ctx", res, exp);
            // R7 strip
            c = {$urandom, $urandom};
            run(2'(2 + (i % 2)), c, 64'd0, k, 1'b0, res, err, lat, bs);
            check("R7 strip", res, canon_of(c));
            check("R7 strip err", 64'(err), 64'd0);
            check("R7 latency", 64'(lat), 64'd1);
        end

        // R6 non-canonical sign, then authenticate it
        p = 64'h1234_0000_dead_beef;
        c = 64'h55;
        k = {64'hfeed_face_cafe_f00d, 64'h0123_4567_89ab_cdef};
        run(2'b00, p, c, k, 1'b0, s, err, lat, bs);
        check("R6 sign poison", s, {2'b10, ref_tag(p, c, k)[13:0], p[47:0]});
        check("R6 sign err", 64'(err), 64'd1);
        run(2'b01, s, c, k, 1'b0, res, err, lat, bs);
        check("R6 auth fails", 64'(err), 64'd1);
        check("R6 auth value", res, {2'b10, canon_of(p)[61:0]});

        // R3 search for a raw tag with top bits 10, check the adjusted result
        for (int j = 0; j < 64; j++) begin
            p = 64'(j) << 4;
            run(2'b00, p, 64'd7, k, 1'b0, s, err, lat, bs);
            check("R3 tag top", s, {ref_tag(p, 64'd7, k), p[47:0]});
        end

        // R9 requests while busy are ignored
        p = rnd_canon();
        run(2'b00, p, 64'd9, k, 1'b1, s, err, lat, bs);
        check("R9 ignored", s, {ref_tag(p, 64'd9, k), p[47:0]});
        @(negedge clk);
        check("R9 idle again", 64'(req_ready), 64'd1);

        // R10 response held under back-pressure
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'b00; req_ptr = p; req_ctx = 64'd3; req_key = k;
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_valid) @(negedge clk);
        s = rsp_ptr;
        repeat (3) @(negedge clk);
        check("R10 valid held", 64'(rsp_valid), 64'd1);
        check("R10 ptr held", rsp_ptr, s);
        check("R10 value", s, {ref_tag(p, 64'd3, k), p[47:0]});
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule